// File: doc/BRIEF.md
# System clock source and divider control

This block holds the control byte that chooses the system clock source and the divider of the internal RC clock. It also decides when a new choice reaches the clock outputs. Software writes the byte through a single-cycle write strobe and reads it back at any time. Clocks are not generated here. The outputs are select codes and enables, and a downstream clock mux and oscillators act on them.

A change-mode bit sets the timing of a new source or divider. In software mode the change reaches the outputs on the next clock edge. In hardware mode the written value waits until a stop entry is followed by a wake-up. The block also gates the two oscillator enables, and a fuse input can force the crystal off. It also turns one bit into a deep-stop or light-stop flag, which is valid only in one power mode.

Top module: `clk_src_ctl`

## Requirements
- R1: After reset, `rd_data` reads 0x24 and `src_sel` is 00. `sys_div` is 01, `rc_osc_en` is 1 and `xtal_osc_en` is 0 (with `xtal_fuse_ok` = 1).
- R2: `rd_data` returns the last byte written. Field layout: bit 7 is stop depth, bits 6:5 are the divider, bit 4 is the change mode (1 = software), bit 3 stops RC, bit 2 stops the crystal, and bits 1:0 are the source.
- R3: `sys_div` code 00, 01, 10 or 11 divides the RC clock by 1, 2, 4 or 8, that is by 2 to the power of the code.
- R4: `sys_div` carries the applied divider only while the applied source is 00 (internal RC). For any other source it is 00.
- R5: A write with bit 4 = 1 puts its source and divider on `src_sel` and `sys_div` on the next cycle.
- R6: A write with bit 4 = 0 leaves `src_sel` and `sys_div` unchanged. The written values are committed on the cycle after `wake_up` is seen following a `stop_enter`.
- R7: A `wake_up` with no earlier `stop_enter` commits nothing. A stop/wake pair with no new write leaves the selection unchanged.
- R8: In software mode, `rc_osc_en` = !bit3 and `xtal_osc_en` = !bit2. In hardware mode, `rc_osc_en` is 1 and `xtal_osc_en` is 1 only when the applied or written source is 01 (crystal).
- R9: While `xtal_fuse_ok` is 0, bit 2 of `rd_data` reads 1 and `xtal_osc_en` is 0.
- R10: `stop_deep` is 1 only when `pwr_mode` = 0x03 and bit 7 = 0. `stop_light` is 1 only when `pwr_mode` = 0x03 and bit 7 = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control byte |
| wr_data | input | 8 | Byte to write |
| rd_data | output | 8 | Control byte as read back |
| stop_enter | input | 1 | Strobe: the CPU enters stop |
| wake_up | input | 1 | Strobe: the CPU wakes from stop |
| xtal_fuse_ok | input | 1 | Fuse that permits the crystal |
| pwr_mode | input | 8 | Current power-mode value |
| src_sel | output | 2 | Applied clock source code |
| sys_div | output | 2 | Effective RC divider code (log2 of the ratio) |
| rc_osc_en | output | 1 | Internal RC oscillator enable |
| xtal_osc_en | output | 1 | Crystal oscillator enable |
| stop_deep | output | 1 | Deep stop selected |
| stop_light | output | 1 | Light stop selected |

## Verification
A corrupted applied copy shows on `src_sel` or `sys_div` in the cycle after the bad update. A lost or spurious stop arming shows only at the next wake-up: either a commit that never happens or one that happens without a stop. The read path and the enable gating are combinational from the stored byte, so a wrong bit there shows in the cycle right after the write.

// File: rtl/clk_src_ctl.sv
module clk_src_ctl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  output logic [7:0] rd_data,
  input  logic       stop_enter,
  input  logic       wake_up,
  input  logic       xtal_fuse_ok,
  input  logic [7:0] pwr_mode,
  output logic [1:0] src_sel,
  output logic [1:0] sys_div,
  output logic       rc_osc_en,
  output logic       xtal_osc_en,
  output logic       stop_deep,
  output logic       stop_light
);
  localparam logic [7:0] RESET_VAL = 8'h24;
  localparam logic [1:0] SRC_RC    = 2'b00;
  localparam logic [1:0] SRC_XTAL  = 2'b01;
  localparam logic [7:0] MODE_STOP = 8'h03;

  logic [7:0] ctl_q;
  logic [1:0] app_src_q, app_div_q;
  logic       armed_q;

  wire sw_mode  = ctl_q[4];
  wire sw_write = wr_en && wr_data[4];
  wire commit   = wake_up && armed_q;
  wire xstop    = ctl_q[2] | ~xtal_fuse_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q     <= RESET_VAL;
      app_src_q <= RESET_VAL[1:0];
      app_div_q <= RESET_VAL[6:5];
      armed_q   <= 1'b0;
    end else begin
      if (wr_en) ctl_q <= wr_data;
      if (sw_write) begin
        app_src_q <= wr_data[1:0];
        app_div_q <= wr_data[6:5];
      end else if (commit) begin
        app_src_q <= ctl_q[1:0];
        app_div_q <= ctl_q[6:5];
      end
      if (wake_up)         armed_q <= 1'b0;
      else if (stop_enter) armed_q <= 1'b1;
    end
  end

  assign rd_data     = {ctl_q[7:3], xstop, ctl_q[1:0]};
  assign src_sel     = app_src_q;
  assign sys_div     = (app_src_q == SRC_RC) ? app_div_q : 2'b00;
  assign rc_osc_en   = sw_mode ? ~ctl_q[3] : 1'b1;
  assign xtal_osc_en = xtal_fuse_ok &&
                       (sw_mode ? ~ctl_q[2]
                                : (app_src_q == SRC_XTAL || ctl_q[1:0] == SRC_XTAL));
  assign stop_deep   = (pwr_mode == MODE_STOP) && !ctl_q[7];
  assign stop_light  = (pwr_mode == MODE_STOP) && ctl_q[7];

  p_div_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel != SRC_RC) |-> (sys_div == 2'b00));

  p_sw_apply_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sw_write |=> (src_sel == $past(wr_data[1:0])));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !wake_up) |=> ($stable(src_sel) && $stable(sys_div)));

  p_rc_on_hw_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_data[4] |-> rc_osc_en);

  p_fuse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !xtal_fuse_ok |-> (!xtal_osc_en && rd_data[2]));

  p_stop_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(stop_deep && stop_light));
endmodule

// File: tb/clk_src_ctl_bench.sv
`timescale 1ns/1ps
module clk_src_ctl_bench;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, stop_enter = 0, wake_up = 0, xtal_fuse_ok = 1;
  logic [7:0] wr_data = 0, pwr_mode = 0, rd_data;
  logic [1:0] src_sel, sys_div;
  logic rc_osc_en, xtal_osc_en, stop_deep, stop_light;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  clk_src_ctl u_clk_src_ctl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .stop_enter(stop_enter), .wake_up(wake_up), .xtal_fuse_ok(xtal_fuse_ok),
    .pwr_mode(pwr_mode), .src_sel(src_sel), .sys_div(sys_div),
    .rc_osc_en(rc_osc_en), .xtal_osc_en(xtal_osc_en),
    .stop_deep(stop_deep), .stop_light(stop_light));

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    wr_data = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse_stop();
    stop_enter = 1; @(negedge clk); stop_enter = 0;
  endtask

  task automatic pulse_wake();
    wake_up = 1; @(negedge clk); wake_up = 0;
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 rd", rd_data, 8'h24);
    chk("R1 src", src_sel, 0);
    chk("R1 div", sys_div, 1);
    chk("R1 rc_en", rc_osc_en, 1);
    chk("R1 xtal_en", xtal_osc_en, 0);

    // R5 R3 R4 R2 software-mode sweep
    for (int s = 0; s < 4; s++)
      for (int d = 0; d < 4; d++) begin
        logic [7:0] v;
        int ed;
        v = {1'b0, d[1:0], 1'b1, 2'b00, s[1:0]};
        wr(v);
        ed = (s == 0) ? d : 0;
        chk("R5 src", src_sel, s);
        chk("R4 div", sys_div, ed);
        chk("R3 ratio", 1 << sys_div, 1 << ed);
        chk("R2 rd", rd_data, v);
      end

    // R8 software-mode oscillator stops
    wr(8'h1C);
    chk("R8 sw rc off", rc_osc_en, 0);
    chk("R8 sw xtal off", xtal_osc_en, 0);
    wr(8'h10);
    chk("R8 sw rc on", rc_osc_en, 1);
    chk("R8 sw xtal on", xtal_osc_en, 1);

    // R6 R7 hardware-mode deferral
    wr(8'h6C);
    chk("R6 deferred div", sys_div, 0);
    chk("R8 hw rc kept", rc_osc_en, 1);
    chk("R8 hw xtal idle", xtal_osc_en, 0);
    pulse_wake();
    chk("R7 wake alone", sys_div, 0);
    pulse_stop();
    chk("R6 after stop", sys_div, 0);
    pulse_wake();
    chk("R6 commit div", sys_div, 3);
    wr(8'h21);
    chk("R6 src held", src_sel, 0);
    chk("R6 div held", sys_div, 3);
    chk("R8 hw xtal pending", xtal_osc_en, 1);
    pulse_stop(); pulse_wake();
    chk("R6 commit src", src_sel, 1);
    chk("R4 div gated", sys_div, 0);
    pulse_stop(); pulse_wake();
    chk("R7 no change src", src_sel, 1);
    chk("R8 hw xtal applied", xtal_osc_en, 1);

    // R10 stop depth sweep
    for (int b = 0; b < 2; b++) begin
      wr({b[0], 7'h21});
      for (int p = 0; p < 256; p++) begin
        pwr_mode = p[7:0];
        #1;
        chk("R10 deep", stop_deep, (p == 3 && b == 0) ? 1 : 0);
        chk("R10 light", stop_light, (p == 3 && b == 1) ? 1 : 0);
      end
    end
    pwr_mode = 0;

    // R9 fuse override sweep
    xtal_fuse_ok = 0;
    for (int v = 0; v < 256; v++) begin
      wr(v[7:0]);
      chk("R9 rd bit2", rd_data, v | 4);
      chk("R9 xtal off", xtal_osc_en, 0);
    end
    xtal_fuse_ok = 1;
    wr(8'h10);
    #1;
    chk("R9 fuse restored", rd_data, 8'h10);
    chk("R9 xtal back", xtal_osc_en, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule